// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Bridge

This block connects two 8-bit buses, side A and side B. Each side has its own capture register. A word is passed from one side to the other in one of two ways: it goes straight through from the live bus, or it comes from the stored word of the opposite side. An active-low output enable and a direction line decide which side, if any, is driven. Two select lines decide, one for each direction, whether the driven side gets live or stored data.

The two buses are modelled as separate input, output and output-enable vectors instead of tristate pins. Two capture strobes arrive asynchronously. Each one passes through a synchroniser on the system clock, and the block reacts to its rising edge. Capture is always active. It works while the outputs are disabled, which gives an isolation mode in which data can still be stored. It also works while the captured side is itself being driven; the register then takes the value the block is putting out on that side.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high, both `a_oe` and `b_oe` are all zeros. After `rst` falls, both capture registers read zero through a stored transfer.
- R2: When `cap_a` goes from low to high, register A loads the effective side-A word. The new value is visible from the third rising `clk` edge at which `cap_a` is sampled high.
- R3: When `cap_b` goes from low to high, register B loads the effective side-B word, with the same latency as R2.
- R4: With `en_n` high, `a_oe` and `b_oe` stay all zeros, but rising strobes still load both registers.
- R5: With `en_n` low and `to_b` high, side B is driven and side A is not. With `en_n` low and `to_b` low, side A is driven and side B is not. The two sides are never driven at the same time.
- R6: When side B is driven, `b_out` equals `a_in` if `use_reg_a` is 0, and equals register A if `use_reg_a` is 1.
- R7: When side A is driven, `a_out` equals `b_in` if `use_reg_b` is 0, and equals register B if `use_reg_b` is 1.
- R8: The effective word of a side is its own output value when that side is driven, and its input vector otherwise.
- R9: A register changes only on a rising edge of its strobe. If the strobe is held high, or never rises, the register keeps its value even when its input changes.
- R10: Each enable vector is either all ones or all zeros. An output vector reads zero while its enable is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Word present on side A from outside |
| a_out | output | 8 | Word driven onto side A |
| a_oe | output | 8 | Drive enable for side A, one bit per line |
| b_in | input | 8 | Word present on side B from outside |
| b_out | output | 8 | Word driven onto side B |
| b_oe | output | 8 | Drive enable for side B, one bit per line |
| cap_a | input | 1 | Capture strobe for register A, asynchronous |
| cap_b | input | 1 | Capture strobe for register B, asynchronous |
| use_reg_a | input | 1 | Source for side B: 0 live side A, 1 register A |
| use_reg_b | input | 1 | Source for side A: 0 live side B, 1 register B |
| to_b | input | 1 | Direction: 1 drives side B, 0 drives side A |
| en_n | input | 1 | Output enable, active low |

## Verification
The assertions assume that reset is applied before anything else happens, so that the synchroniser history and both registers start from known zeros. They also assume that the control and data inputs change only between clock edges. The stimulus holds every input constant for a whole cycle and drives it just after the rising edge. It keeps the side being captured unchanged until the third edge of the strobe window, so the bench knows exactly which word each capture loads.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_LIVE   = 2'd1,
    SRC_STORED = 2'd2
  } src_e;

  function automatic src_e pick_source(input logic drive, input logic stored);
    if (!drive)      return SRC_NONE;
    else if (stored) return SRC_STORED;
    else             return SRC_LIVE;
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[DEPTH-2:0], strobe};
  end

  assign rise = hist[STAGES-1] & ~hist[STAGES];

  // A single rising edge yields a one-cycle pulse (R9)
  p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // Load takes the word presented in the load cycle (R2, R3)
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));

  // Without a load pulse the word is kept (R9)
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/port_drive.sv
module port_drive
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  src_e src;

  assign src = pick_source(drive, use_stored);

  always_comb begin
    unique case (src)
      SRC_LIVE:   dout = live;
      SRC_STORED: dout = stored;
      default:    dout = '0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_oe
    assign oe[i] = (src != SRC_NONE);
  end

  // Enable vector is uniform, idle output reads zero (R10)
  always_comb begin
    p_oe_uniform_r10: assert (oe == '0 || oe == '1);
    p_idle_zero_r10:  assert (oe != '0 || dout == '0);
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         use_reg_a,
  input  logic         use_reg_b,
  input  logic         to_b,
  input  logic         en_n
);
  logic         rise_a, rise_b;
  logic         drive_a, drive_b;
  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] eff_a, eff_b;

  assign drive_a = ~rst & ~en_n & ~to_b;
  assign drive_b = ~rst & ~en_n &  to_b;

  strobe_edge #(.STAGES(SYNC_STAGES)) u_edge_a (
    .clk(clk), .rst(rst), .strobe(cap_a), .rise(rise_a));
  strobe_edge #(.STAGES(SYNC_STAGES)) u_edge_b (
    .clk(clk), .rst(rst), .strobe(cap_b), .rise(rise_b));

  assign eff_a = a_oe[0] ? a_out : a_in;
  assign eff_b = b_oe[0] ? b_out : b_in;

  capture_reg #(.W(W)) u_reg_a (
    .clk(clk), .rst(rst), .load(rise_a), .d(eff_a), .q(reg_a));
  capture_reg #(.W(W)) u_reg_b (
    .clk(clk), .rst(rst), .load(rise_b), .d(eff_b), .q(reg_b));

  // Live path uses the opposite input vector: when one side drives, the other is undriven
  port_drive #(.W(W)) u_drv_b (
    .drive(drive_b), .use_stored(use_reg_a), .live(a_in), .stored(reg_a),
    .dout(b_out), .oe(b_oe));
  port_drive #(.W(W)) u_drv_a (
    .drive(drive_a), .use_stored(use_reg_b), .live(b_in), .stored(reg_b),
    .dout(a_out), .oe(a_oe));

  p_never_both_r5: assert property (@(posedge clk) disable iff (rst)
    !(a_oe[0] && b_oe[0]));

  p_isolate_r4: assert property (@(posedge clk) disable iff (rst)
    en_n |-> (a_oe == '0 && b_oe == '0));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (a_oe == '0 && b_oe == '0));

endmodule

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         cap_a = 1'b0, cap_b = 1'b0;
  logic         use_reg_a = 1'b0, use_reg_b = 1'b0, to_b = 1'b0, en_n = 1'b1;

  always #2 clk = ~clk;

  bus_xcvr_reg #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_a(cap_a), .cap_b(cap_b),
    .use_reg_a(use_reg_a), .use_reg_b(use_reg_b), .to_b(to_b), .en_n(en_n));

  typedef struct {
    string        tag;
    logic [W-1:0] ao, bo;
    logic         aoe, boe;
  } item_t;

  item_t        sb[$];
  int           n_checks = 0;
  int           n_fail   = 0;
  logic [W-1:0] ra = '0, rb = '0;
  bit           done = 0;

  function automatic item_t model(string tag);
    item_t e;
    e.tag = tag;
    e.aoe = !rst && !en_n && !to_b;
    e.boe = !rst && !en_n &&  to_b;
    e.bo  = e.boe ? (use_reg_a ? ra : a_in) : '0;
    e.ao  = e.aoe ? (use_reg_b ? rb : b_in) : '0;
    return e;
  endfunction

  task automatic expect_now(string tag);
    sb.push_back(model(tag));
    @(posedge clk); #1;
  endtask

  task automatic ctrl(logic n, logic d, logic sa, logic sb_);
    en_n = n; to_b = d; use_reg_a = sa; use_reg_b = sb_;
  endtask

  // Effective side value as seen by the model (R8)
  function automatic logic [W-1:0] eff(bit side_b);
    item_t e;
    e = model("");
    if (side_b) return e.boe ? e.bo : b_in;
    else        return e.aoe ? e.ao : a_in;
  endfunction

  task automatic capture(bit side_b, bit keep_high);
    logic [W-1:0] v;
    v = eff(side_b);
    if (side_b) cap_b = 1'b1; else cap_a = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    if (side_b) rb = v; else ra = v;
    if (!keep_high) begin
      cap_a = 1'b0; cap_b = 1'b0;
      repeat (3) @(posedge clk);
      #1;
    end
  endtask

  always @(negedge clk) begin
    while (sb.size() != 0) begin
      item_t e;
      e = sb.pop_front();
      n_checks++;
      if (a_oe !== {W{e.aoe}} || b_oe !== {W{e.boe}} ||
          a_out !== e.ao || b_out !== e.bo) begin
        n_fail++;
        $display("FAIL %s: got a_oe=%h a_out=%h b_oe=%h b_out=%h, expected a_oe=%h a_out=%h b_oe=%h b_out=%h",
                 e.tag, a_oe, a_out, b_oe, b_out, {W{e.aoe}}, e.ao, {W{e.boe}}, e.bo);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    ctrl(0, 1, 1, 0); a_in = 8'h77;
    expect_now("R1 enables off in reset");
    expect_now("R1 enables off in reset, second cycle");
    rst = 1'b0;
    expect_now("R1 register A zero after reset");
    ctrl(0, 0, 1, 1);
    expect_now("R1 register B zero after reset");

    // Live transfers
    ctrl(0, 1, 0, 0); a_in = 8'hC3;
    expect_now("R6 R5 live A to B");
    a_in = 8'h18;
    expect_now("R6 live A to B second word");
    ctrl(0, 0, 0, 0); b_in = 8'h96;
    expect_now("R7 R5 live B to A");
    b_in = 8'h01;
    expect_now("R7 live B to A second word");

    // Isolation with storage
    ctrl(1, 1, 1, 1); a_in = 8'h3C; b_in = 8'hA5;
    expect_now("R4 isolation, no enables");
    capture(0, 0);
    capture(1, 0);
    expect_now("R4 isolation after captures");
    a_in = 8'h00; b_in = 8'hFF;
    ctrl(0, 1, 1, 0);
    expect_now("R2 R6 stored A word on B");
    ctrl(0, 0, 0, 1);
    expect_now("R3 R7 stored B word on A");

    // Capture of the driven side takes its own output
    ctrl(0, 1, 0, 0); a_in = 8'h5A; b_in = 8'h11;
    capture(1, 0);
    ctrl(0, 0, 0, 1); a_in = 8'h22;
    expect_now("R8 B register took driven B word");
    ctrl(0, 0, 1, 0); b_in = 8'h4D;
    capture(0, 0);
    ctrl(0, 1, 1, 0); a_in = 8'h99;
    expect_now("R8 A register took driven A word");

    // Hold behaviour
    ctrl(0, 1, 1, 0); a_in = 8'hE7;
    expect_now("R9 no strobe, A register kept");
    capture(0, 1);
    a_in = 8'h6B;
    repeat (4) @(posedge clk);
    #1;
    expect_now("R9 strobe held high, no second load");
    cap_a = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    expect_now("R9 strobe falling, no load");
    capture(0, 0);
    expect_now("R2 new rising edge loads again");

    // Sweep of all control combinations
    for (int k = 0; k < 16; k++) begin
      ctrl(k[0], k[1], k[2], k[3]);
      a_in = 8'(k * 17 + 3);
      b_in = 8'(~(k * 29));
      expect_now("R10 R5 control sweep");
    end

    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule